// File: doc/BRIEF.md
# Codec Sample Data-Valid Flag Generator

This block sits on the converter side of a serial codec link. It decides, for every frame that goes back to the host, whether each channel's data-valid bit is set, and it supplies the 16-bit sample field for that frame. There are two channels: an audio channel with 12-bit samples and a telecom channel with 14-bit samples. Each sample is placed in the upper bits of its 16-bit field, and the bits below it are zero.

Each channel has one of two valid policies. In sticky mode, the bit goes high once the channel is enabled and has taken a sample. It then stays high until the channel is disabled. In one-shot mode, the bit marks only a fresh conversion. It drops after one frame strobe has carried that sample, and it stays low until the next sample strobe.

The mode is a configuration input for each channel. The block latches it only while that channel is disabled. The frame serializer and the converters are outside this block. It sees them only as a frame strobe and one sample strobe per channel.

Top module: `codec_dv_gen`

## Requirements
- R1: After reset, both valid outputs are 0 and both field outputs are 0x0000.
- R2: A sample strobe on an enabled channel loads the sample into the field on the next clock. The sample sits in the upper bits of the field: audio bits [15:4] with bits [3:0] zero, and telecom bits [15:2] with bits [1:0] zero.
- R3: In sticky mode (mode input 0), the valid bit goes to 1 on the clock after the first sample strobe while the channel is enabled. It then stays 1 through any number of frame strobes for as long as the channel stays enabled.
- R4: A low enable clears that channel's valid bit and field on the next clock. After the channel is re-enabled, the valid bit stays 0 until a new sample strobe arrives.
- R5: In one-shot mode (mode input 1), the valid bit goes to 1 on the clock after a sample strobe. It goes to 0 on the clock after a frame strobe that arrives without a sample strobe, and then stays 0 until the next sample strobe.
- R6: When a sample strobe and a frame strobe arrive in the same cycle, the sample wins. The valid bit is 1 on the next clock and the field holds the new sample.
- R7: Sample strobes on a disabled channel are ignored. Its valid bit and field stay 0.
- R8: The mode input takes effect only while its channel is disabled. A change to the mode input while the channel is enabled does not change that channel's behaviour until it has been disabled.
- R9: The two channels are independent. One channel's enable, strobe or mode never changes the other channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_stb_i | input | 1 | One-cycle strobe: the current frame has been sent |
| aud_en_i | input | 1 | Audio converter enable |
| aud_oneshot_i | input | 1 | Audio mode: 0 sticky, 1 one-shot |
| aud_stb_i | input | 1 | Audio new-sample strobe |
| aud_smp_i | input | 12 | Audio sample |
| tel_en_i | input | 1 | Telecom converter enable |
| tel_oneshot_i | input | 1 | Telecom mode: 0 sticky, 1 one-shot |
| tel_stb_i | input | 1 | Telecom new-sample strobe |
| tel_smp_i | input | 14 | Telecom sample |
| aud_vld_o | output | 1 | Audio data-valid bit for the next frame |
| aud_fld_o | output | 16 | Audio sample field, sample in the upper bits |
| tel_vld_o | output | 1 | Telecom data-valid bit for the next frame |
| tel_fld_o | output | 16 | Telecom sample field, sample in the upper bits |

## Verification
A sample strobe and a frame strobe can arrive in the same cycle. In one-shot mode the two pull the valid bit in opposite directions. The bench forces this case on the telecom channel after an earlier frame strobe has already dropped the bit. It then expects the bit to be 1 with the new sample in the field, followed by a clear on the next frame strobe alone. A long random stretch drives frame and sample strobes together often, toggles enables and modes, and compares both channels against the reference model on every clock.

// File: rtl/codec_dv_pkg.sv
package codec_dv_pkg;
  localparam int FLD_W = 16;

  typedef enum logic {
    MODE_STICKY  = 1'b0,
    MODE_ONESHOT = 1'b1
  } dv_mode_e;
endpackage

// File: rtl/dv_mode_latch.sv
module dv_mode_latch
  import codec_dv_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     oneshot_i,
  output dv_mode_e mode_o
);
  dv_mode_e mode_q;

  // mode only follows the input while the channel is off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mode_q <= MODE_STICKY;
    else if (!en_i) mode_q <= dv_mode_e'(oneshot_i);
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/dv_flag_ctl.sv
module dv_flag_ctl
  import codec_dv_pkg::*;
#(
  parameter int SMP_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             stb_i,
  input  logic             frm_stb_i,
  input  dv_mode_e         mode_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic             vld_o,
  output logic [SMP_W-1:0] hold_o
);
  logic             vld_q, vld_d;
  logic [SMP_W-1:0] hold_q, hold_d;

  always_comb begin
    vld_d  = vld_q;
    hold_d = hold_q;
    if (!en_i) begin
      vld_d  = 1'b0;
      hold_d = '0;
    end else if (stb_i) begin
      // a new sample beats a concurrent frame strobe
      vld_d  = 1'b1;
      hold_d = smp_i;
    end else if (frm_stb_i && mode_i == MODE_ONESHOT) begin
      vld_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      vld_q  <= vld_d;
      hold_q <= hold_d;
    end
  end

  assign vld_o  = vld_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/dv_field_pack.sv
module dv_field_pack #(
  parameter int SMP_W = 12,
  parameter int FLD_W = 16
) (
  input  logic [SMP_W-1:0] smp_i,
  output logic [FLD_W-1:0] fld_o
);
  localparam int PAD_W = FLD_W - SMP_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign fld_o = {smp_i, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign fld_o = smp_i[SMP_W-1 -: FLD_W];
    end
  endgenerate
endmodule

// File: rtl/dv_channel.sv
module dv_channel
  import codec_dv_pkg::*;
#(
  parameter int SMP_W = 12,
  parameter int FLD_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             oneshot_i,
  input  logic             stb_i,
  input  logic             frm_stb_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic             vld_o,
  output logic [FLD_W-1:0] fld_o,
  output logic             oneshot_o
);
  dv_mode_e         mode;
  logic [SMP_W-1:0] hold;

  dv_mode_latch u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .oneshot_i(oneshot_i),
    .mode_o   (mode)
  );

  dv_flag_ctl #(.SMP_W(SMP_W)) u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .stb_i    (stb_i),
    .frm_stb_i(frm_stb_i),
    .mode_i   (mode),
    .smp_i    (smp_i),
    .vld_o    (vld_o),
    .hold_o   (hold)
  );

  dv_field_pack #(.SMP_W(SMP_W), .FLD_W(FLD_W)) u_pack (
    .smp_i(hold),
    .fld_o(fld_o)
  );

  assign oneshot_o = (mode == MODE_ONESHOT);
endmodule

// File: rtl/codec_dv_gen.sv
module codec_dv_gen
  import codec_dv_pkg::*;
#(
  parameter int AUD_W = 12,
  parameter int TEL_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frm_stb_i,
  input  logic             aud_en_i,
  input  logic             aud_oneshot_i,
  input  logic             aud_stb_i,
  input  logic [AUD_W-1:0] aud_smp_i,
  input  logic             tel_en_i,
  input  logic             tel_oneshot_i,
  input  logic             tel_stb_i,
  input  logic [TEL_W-1:0] tel_smp_i,
  output logic             aud_vld_o,
  output logic [FLD_W-1:0] aud_fld_o,
  output logic             tel_vld_o,
  output logic [FLD_W-1:0] tel_fld_o
);
  logic aud_mode_os;
  logic tel_mode_os;

  dv_channel #(.SMP_W(AUD_W), .FLD_W(FLD_W)) u_aud (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (aud_en_i),
    .oneshot_i(aud_oneshot_i),
    .stb_i    (aud_stb_i),
    .frm_stb_i(frm_stb_i),
    .smp_i    (aud_smp_i),
    .vld_o    (aud_vld_o),
    .fld_o    (aud_fld_o),
    .oneshot_o(aud_mode_os)
  );

  dv_channel #(.SMP_W(TEL_W), .FLD_W(FLD_W)) u_tel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (tel_en_i),
    .oneshot_i(tel_oneshot_i),
    .stb_i    (tel_stb_i),
    .frm_stb_i(frm_stb_i),
    .smp_i    (tel_smp_i),
    .vld_o    (tel_vld_o),
    .fld_o    (tel_fld_o),
    .oneshot_o(tel_mode_os)
  );
endmodule

// File: rtl/codec_dv_chk.sv
module codec_dv_chk #(
  parameter int FLD_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             stb_i,
  input logic             frm_i,
  input logic             os_i,
  input logic             vld_i,
  input logic [FLD_W-1:0] fld_i
);
  assert_disable_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!vld_i && fld_i == '0));

  assert_sample_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && stb_i) |=> vld_i);

  assert_sticky_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && vld_i && !os_i) |=> vld_i);

  assert_oneshot_drops_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !stb_i && frm_i && os_i) |=> !vld_i);

  assert_no_spurious_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && !(en_i && stb_i)) |=> !vld_i);

  assert_mode_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> $stable(os_i));
endmodule

bind codec_dv_gen codec_dv_chk #(.FLD_W(codec_dv_pkg::FLD_W)) u_chk_aud (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .en_i  (aud_en_i),
  .stb_i (aud_stb_i),
  .frm_i (frm_stb_i),
  .os_i  (aud_mode_os),
  .vld_i (aud_vld_o),
  .fld_i (aud_fld_o)
);

bind codec_dv_gen codec_dv_chk #(.FLD_W(codec_dv_pkg::FLD_W)) u_chk_tel (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .en_i  (tel_en_i),
  .stb_i (tel_stb_i),
  .frm_i (frm_stb_i),
  .os_i  (tel_mode_os),
  .vld_i (tel_vld_o),
  .fld_i (tel_fld_o)
);

// File: tb/tb_codec_dv_gen.sv
`timescale 1ns/1ps
module tb_codec_dv_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm = 1'b0;
  logic        a_en = 1'b0, a_os = 1'b0, a_stb = 1'b0;
  logic [11:0] a_smp = '0;
  logic        t_en = 1'b0, t_os = 1'b0, t_stb = 1'b0;
  logic [13:0] t_smp = '0;
  logic        a_vld, t_vld;
  logic [15:0] a_fld, t_fld;

  int    n_vec = 0;
  int    n_bad = 0;
  string phase = "R1";
  bit    done = 1'b0;

  // behavioural reference
  int m_a_vld = 0, m_a_os = 0, m_a_hold = 0;
  int m_t_vld = 0, m_t_os = 0, m_t_hold = 0;

  always #4 clk = ~clk;

  codec_dv_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .frm_stb_i(frm),
    .aud_en_i(a_en), .aud_oneshot_i(a_os), .aud_stb_i(a_stb), .aud_smp_i(a_smp),
    .tel_en_i(t_en), .tel_oneshot_i(t_os), .tel_stb_i(t_stb), .tel_smp_i(t_smp),
    .aud_vld_o(a_vld), .aud_fld_o(a_fld), .tel_vld_o(t_vld), .tel_fld_o(t_fld)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a_vld = 0; m_a_os = 0; m_a_hold = 0;
      m_t_vld = 0; m_t_os = 0; m_t_hold = 0;
    end else begin
      if (!a_en) begin m_a_os = a_os; m_a_vld = 0; m_a_hold = 0; end
      else if (a_stb) begin m_a_vld = 1; m_a_hold = a_smp; end
      else if (frm && m_a_os == 1) m_a_vld = 0;
      if (!t_en) begin m_t_os = t_os; m_t_vld = 0; m_t_hold = 0; end
      else if (t_stb) begin m_t_vld = 1; m_t_hold = t_smp; end
      else if (frm && m_t_os == 1) m_t_vld = 0;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(phase, "aud_vld", int'(a_vld), m_a_vld);
      chk(phase, "aud_fld", int'(a_fld), (m_a_hold << 4) & 16'hFFFF);
      chk(phase, "tel_vld", int'(t_vld), m_t_vld);
      chk(phase, "tel_fld", int'(t_fld), (m_t_hold << 2) & 16'hFFFF);
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired in phase %s", phase);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1", "aud_vld reset", int'(a_vld), 0);
    chk("R1", "tel_fld reset", int'(t_fld), 0);
    rst_n = 1'b1;
    tick();

    phase = "R7";
    a_stb = 1; a_smp = 12'hABC; t_stb = 1; t_smp = 14'h1234;
    tick();
    a_stb = 0; t_stb = 0;
    chk("R7", "aud_vld disabled strobe", int'(a_vld), 0);
    chk("R7", "aud_fld disabled strobe", int'(a_fld), 0);
    chk("R7", "tel_vld disabled strobe", int'(t_vld), 0);

    phase = "R3";
    a_os = 0; t_os = 1;
    tick();
    a_en = 1; t_en = 1;
    tick();
    a_stb = 1; a_smp = 12'hABC;
    tick();
    a_stb = 0;
    chk("R3", "aud_vld after sample", int'(a_vld), 1);
    chk("R2", "aud_fld left-justified", int'(a_fld), 16'hABC0);
    frm = 1; tick(3); frm = 0;
    chk("R3", "aud_vld after frames", int'(a_vld), 1);

    phase = "R8";
    a_os = 1;
    frm = 1; tick(2); frm = 0;
    chk("R8", "aud_vld mode change while enabled", int'(a_vld), 1);

    phase = "R5";
    t_stb = 1; t_smp = 14'h2A5F;
    tick();
    t_stb = 0;
    chk("R5", "tel_vld after sample", int'(t_vld), 1);
    chk("R2", "tel_fld left-justified", int'(t_fld), 16'hA97C);
    tick(2);
    chk("R5", "tel_vld held without frame", int'(t_vld), 1);
    frm = 1; tick(); frm = 0;
    chk("R5", "tel_vld after frame", int'(t_vld), 0);
    tick(3);
    chk("R5", "tel_vld stays clear", int'(t_vld), 0);

    phase = "R6";
    frm = 1; t_stb = 1; t_smp = 14'h3FFF;
    tick();
    frm = 0; t_stb = 0;
    chk("R6", "tel_vld sample beats frame", int'(t_vld), 1);
    chk("R6", "tel_fld new sample", int'(t_fld), 16'hFFFC);
    frm = 1; tick(); frm = 0;
    chk("R6", "tel_vld cleared by later frame", int'(t_vld), 0);

    phase = "R9";
    t_en = 0;
    tick();
    chk("R9", "aud_vld with telecom off", int'(a_vld), 1);
    chk("R9", "aud_fld with telecom off", int'(a_fld), 16'hABC0);

    phase = "R4";
    a_en = 0;
    tick();
    chk("R4", "aud_vld after disable", int'(a_vld), 0);
    chk("R4", "aud_fld after disable", int'(a_fld), 0);
    a_os = 0;
    tick();
    a_en = 1;
    tick(3);
    chk("R4", "aud_vld re-enabled no sample", int'(a_vld), 0);
    a_stb = 1; a_smp = 12'h001;
    tick();
    a_stb = 0;
    chk("R4", "aud_vld after new sample", int'(a_vld), 1);
    chk("R2", "aud_fld low sample", int'(a_fld), 16'h0010);

    phase = "R9 random";
    for (int i = 0; i < 4000; i++) begin
      frm   = ($urandom_range(0, 3) == 0);
      a_stb = ($urandom_range(0, 4) == 0);
      t_stb = ($urandom_range(0, 4) == 0);
      a_smp = 12'($urandom);
      t_smp = 14'($urandom);
      if ($urandom_range(0, 29) == 0) a_en = ~a_en;
      if ($urandom_range(0, 29) == 0) t_en = ~t_en;
      if ($urandom_range(0, 9) == 0)  a_os = ~a_os;
      if ($urandom_range(0, 9) == 0)  t_os = ~t_os;
      tick();
    end
    frm = 0; a_stb = 0; t_stb = 0;
    tick(2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule